// File: doc/BRIEF.md
# Beat Width Adapter with Byte and Half-Word Exchange

This block reshapes one data beat of a transfer engine: a beat arrives on a 32-bit lane with its meaningful bytes in the least significant positions, tagged with a source width and a destination width. Each width is a byte, a half-word or a word. The beat leaves as exactly one beat of the destination width. When the widths differ, a one-bit fit mode selects how the beat is converted. A narrow beat grows by zero fill or by sign extension. A wide beat shrinks by keeping either its low part or its high part.

Around the conversion sit three optional exchanges. A source-side exchange swaps the two middle bytes of a word-wide source before conversion. After conversion, a destination byte exchange swaps the bytes inside each half-word, and a destination half-word exchange swaps the two halves of a word. A beat whose width code is not legal is consumed without output and flagged. The whole path is combinational into a single output register, with valid/ready handshakes on both sides.

Top module: `dma_width_conv`

## Requirements
- R1: When source and destination widths are equal, the fit mode has no effect and the beat leaves unchanged apart from the enabled exchanges. Width codes: 0 byte, 1 half-word, 2 word, 3 illegal.
- R2: With a narrower source and fit mode 0, the source bits stay right-aligned and every destination bit above them is zero.
- R3: With a narrower source and fit mode 1, every destination bit above the source takes the value of the source's most significant bit.
- R4: With a wider source and fit mode 0, the output holds the lowest destination-width bits of the source.
- R5: With a wider source and fit mode 1, the output holds the highest destination-width bits of the source (source shifted right by the width difference).
- R6: The source byte exchange (src_swap_b) swaps bits 15:8 with 23:16 before conversion, and only when the source width is a word. For any other source width it has no effect.
- R7: The destination byte exchange (dst_swap_b) swaps the two bytes of every destination half-word after conversion. It has no effect when the destination width is a byte.
- R8: The destination half-word exchange (dst_swap_h) swaps bits 31:16 with 15:0 after the byte exchange, and only for a word destination. With both destination exchanges on, the four bytes of a word are reversed.
- R9: Input bits above the source width are ignored, and output bits above the destination width are zero.
- R10: Each accepted legal beat appears on the output one cycle after acceptance. in_ready equals (not out_valid) or out_ready. A stalled output keeps out_valid and out_data unchanged.
- R11: A beat with width code 3 on either side is accepted and produces no output. err_pulse is high in the cycle after that acceptance, for that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take the input beat |
| in_data | input | 32 | Input beat, right-aligned |
| src_width | input | 2 | Source width code of the beat |
| dst_width | input | 2 | Destination width code of the beat |
| fit_mode | input | 1 | 0: zero fill / keep low, 1: sign extend / keep high |
| src_swap_b | input | 1 | Source middle-byte exchange enable |
| dst_swap_b | input | 1 | Destination byte-in-half-word exchange enable |
| dst_swap_h | input | 1 | Destination half-word exchange enable |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the output beat |
| out_data | output | 32 | Converted beat, right-aligned |
| err_pulse | output | 1 | One-cycle flag for a dropped illegal beat |

## Verification
Two things can happen in the same cycle. The held output beat can drain while a new input beat is accepted, and that new beat may be an illegal one that must clear the output instead of replacing it. The bench drives valid and ready with independent random gaps so that drains, refills and illegal beats overlap. A behavioural per-cycle model predicts in_ready, out_valid, out_data and err_pulse for every cycle and checks them all.

// File: rtl/dwc_pkg.sv
package dwc_pkg;

    localparam int LANE_W   = 32;
    localparam int LANE_B   = LANE_W / 8;
    localparam int HALF_CNT = LANE_W / 16;

    typedef logic [LANE_W-1:0] lane_t;

    typedef enum logic [1:0] {
        WID_BYTE = 2'd0,
        WID_HALF = 2'd1,
        WID_WORD = 2'd2,
        WID_BAD  = 2'd3
    } wid_e;

    typedef struct packed {
        wid_e src_w;
        wid_e dst_w;
        logic fit_hi;
        logic src_bx;
        logic dst_bx;
        logic dst_hx;
    } beat_cfg_t;

    function automatic logic [2:0] wid_bytes(wid_e w);
        case (w)
            WID_BYTE: return 3'd1;
            WID_HALF: return 3'd2;
            default:  return 3'd4;
        endcase
    endfunction

    function automatic lane_t wid_mask(wid_e w);
        case (w)
            WID_BYTE: return lane_t'(32'h0000_00FF);
            WID_HALF: return lane_t'(32'h0000_FFFF);
            default:  return lane_t'(32'hFFFF_FFFF);
        endcase
    endfunction

    function automatic logic wid_legal(wid_e w);
        return w != WID_BAD;
    endfunction

endpackage

// File: rtl/dwc_src_swap.sv
module dwc_src_swap
    import dwc_pkg::*;
(
    input  lane_t din,
    input  wid_e  src_w,
    input  logic  swap_en,
    output lane_t dout
);
    lane_t clean;

    always_comb begin
        clean = din & wid_mask(src_w);
        dout  = clean;
        if (swap_en && src_w == WID_WORD) begin
            dout[15:8]  = clean[23:16];
            dout[23:16] = clean[15:8];
        end
    end
endmodule

// File: rtl/dwc_fit.sv
module dwc_fit
    import dwc_pkg::*;
(
    input  lane_t din,
    input  wid_e  src_w,
    input  wid_e  dst_w,
    input  logic  fit_hi,
    output lane_t dout
);
    logic [2:0] sb;
    logic [2:0] db;
    logic [2:0] diff;
    logic       top_bit;
    lane_t      fill;
    lane_t      shifted;

    always_comb begin
        sb      = wid_bytes(src_w);
        db      = wid_bytes(dst_w);
        diff    = 3'd0;
        fill    = '0;
        shifted = din;
        case (src_w)
            WID_BYTE: top_bit = din[7];
            WID_HALF: top_bit = din[15];
            default:  top_bit = din[31];
        endcase
        if (db > sb) begin
            fill = (fit_hi && top_bit) ? ~wid_mask(src_w) : '0;
            dout = ((din & wid_mask(src_w)) | fill) & wid_mask(dst_w);
        end else if (db < sb) begin
            diff    = sb - db;
            shifted = fit_hi ? (din >> {diff, 3'b000}) : din;
            dout    = shifted & wid_mask(dst_w);
        end else begin
            dout = din & wid_mask(dst_w);
        end
    end
endmodule

// File: rtl/dwc_dst_swap.sv
module dwc_dst_swap
    import dwc_pkg::*;
(
    input  lane_t din,
    input  wid_e  dst_w,
    input  logic  bx_en,
    input  logic  hx_en,
    output lane_t dout
);
    logic  bx_on;
    logic  hx_on;
    lane_t bx_lane;

    assign bx_on = bx_en && (dst_w != WID_BYTE);
    assign hx_on = hx_en && (dst_w == WID_WORD);

    for (genvar h = 0; h < HALF_CNT; h++) begin : g_half
        assign bx_lane[16*h +: 16] = bx_on ? {din[16*h +: 8], din[16*h+8 +: 8]}
                                           : din[16*h +: 16];
    end

    assign dout = hx_on ? {bx_lane[LANE_W/2-1:0], bx_lane[LANE_W-1:LANE_W/2]} : bx_lane;
endmodule

// File: rtl/dwc_stage.sv
module dwc_stage
    import dwc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    output logic  in_ready,
    input  lane_t in_data,
    input  wid_e  in_dst_w,
    input  logic  in_bad,
    output logic  out_valid,
    input  logic  out_ready,
    output lane_t out_data,
    output wid_e  out_dst_w,
    output logic  err_pulse
);
    logic take;

    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_dst_w <= WID_BYTE;
            err_pulse <= 1'b0;
        end else begin
            err_pulse <= take && in_bad;
            if (take) begin
                out_valid <= !in_bad;
                if (!in_bad) begin
                    out_data  <= in_data;
                    out_dst_w <= in_dst_w;
                end
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R10

    AST_GOOD_LANDS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !in_bad) |=> (out_valid && out_data == $past(in_data))); // R10

    AST_BAD_FLAG: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_bad) |=> (err_pulse && !out_valid)); // R11

    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> $past(in_valid && in_bad)); // R11
endmodule

// File: rtl/dma_width_conv.sv
module dma_width_conv
    import dwc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_data,
    input  logic [1:0]  src_width,
    input  logic [1:0]  dst_width,
    input  logic        fit_mode,
    input  logic        src_swap_b,
    input  logic        dst_swap_b,
    input  logic        dst_swap_h,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_data,
    output logic        err_pulse
);
    beat_cfg_t cfg;
    logic      bad;
    lane_t     src_lane;
    lane_t     fit_lane;
    lane_t     dst_lane;
    lane_t     q_data;
    wid_e      q_dst_w;

    assign cfg.src_w  = wid_e'(src_width);
    assign cfg.dst_w  = wid_e'(dst_width);
    assign cfg.fit_hi = fit_mode;
    assign cfg.src_bx = src_swap_b;
    assign cfg.dst_bx = dst_swap_b;
    assign cfg.dst_hx = dst_swap_h;
    assign bad        = !wid_legal(cfg.src_w) || !wid_legal(cfg.dst_w);

    dwc_src_swap u_src (
        .din     (in_data),
        .src_w   (cfg.src_w),
        .swap_en (cfg.src_bx),
        .dout    (src_lane)
    );

    dwc_fit u_fit (
        .din    (src_lane),
        .src_w  (cfg.src_w),
        .dst_w  (cfg.dst_w),
        .fit_hi (cfg.fit_hi),
        .dout   (fit_lane)
    );

    dwc_dst_swap u_dst (
        .din   (fit_lane),
        .dst_w (cfg.dst_w),
        .bx_en (cfg.dst_bx),
        .hx_en (cfg.dst_hx),
        .dout  (dst_lane)
    );

    dwc_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (dst_lane),
        .in_dst_w  (cfg.dst_w),
        .in_bad    (bad),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (q_data),
        .out_dst_w (q_dst_w),
        .err_pulse (err_pulse)
    );

    assign out_data = q_data;

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_data & ~wid_mask(q_dst_w)) == '0)); // R9

    AST_READY_FREE: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready); // R10

    AST_FIT_SIGN: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && fit_mode && src_width == 2'd0 && dst_width == 2'd2
         && in_data[7] && !dst_swap_b && !dst_swap_h)
        |=> (out_data[31:8] == 24'hFF_FFFF)); // R3
endmodule

// File: tb/sim_dma_width_conv.sv
`timescale 1ns/1ps
module sim_dma_width_conv;

    typedef struct {
        logic [31:0] d;
        logic [1:0]  sw;
        logic [1:0]  dw;
        logic        m;
        logic        sbx;
        logic        dbx;
        logic        dhx;
    } stim_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic [1:0]  src_width = '0;
    logic [1:0]  dst_width = '0;
    logic        fit_mode = 1'b0;
    logic        src_swap_b = 1'b0;
    logic        dst_swap_b = 1'b0;
    logic        dst_swap_h = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic        err_pulse;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dma_width_conv u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .src_width(src_width), .dst_width(dst_width),
        .fit_mode(fit_mode), .src_swap_b(src_swap_b), .dst_swap_b(dst_swap_b),
        .dst_swap_h(dst_swap_h), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .err_pulse(err_pulse)
    );

    function automatic logic [31:0] ref_beat(stim_t s);
        logic [7:0] b[4];
        logic [7:0] t;
        logic [7:0] fill;
        int sn, dn;
        for (int k = 0; k < 4; k++) b[k] = s.d[8*k +: 8];
        sn = 1 << s.sw;
        dn = 1 << s.dw;
        for (int k = sn; k < 4; k++) b[k] = 8'h00;
        if (s.sbx && sn == 4) begin t = b[1]; b[1] = b[2]; b[2] = t; end
        if (dn > sn) begin
            fill = (s.m && b[sn-1][7]) ? 8'hFF : 8'h00;
            for (int k = sn; k < dn; k++) b[k] = fill;
        end else if (dn < sn && s.m) begin
            for (int k = 0; k < dn; k++) b[k] = b[k + sn - dn];
        end
        for (int k = dn; k < 4; k++) b[k] = 8'h00;
        if (s.dbx && dn >= 2) begin
            t = b[0]; b[0] = b[1]; b[1] = t;
            if (dn == 4) begin t = b[2]; b[2] = b[3]; b[3] = t; end
        end
        if (s.dhx && dn == 4) begin
            t = b[0]; b[0] = b[2]; b[2] = t;
            t = b[1]; b[1] = b[3]; b[3] = t;
        end
        return {b[3], b[2], b[1], b[0]};
    endfunction

    function automatic string tag_of(stim_t s);
        string r;
        if (s.sw == 2'd3 || s.dw == 2'd3) return "R11";
        if (s.sw == s.dw) r = "R1";
        else if (s.sw < s.dw) r = s.m ? "R3" : "R2";
        else r = s.m ? "R5" : "R4";
        if (s.sbx) r = {r, "/R6"};
        if (s.dbx) r = {r, "/R7"};
        if (s.dhx) r = {r, "/R8"};
        return {r, "/R9"};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic stim_t mk(logic [31:0] d, logic [1:0] sw, logic [1:0] dw,
                                 logic m, logic sbx, logic dbx, logic dhx);
        stim_t s;
        s.d = d; s.sw = sw; s.dw = dw; s.m = m; s.sbx = sbx; s.dbx = dbx; s.dhx = dhx;
        return s;
    endfunction

    stim_t q[$];
    stim_t cur;
    bit    m_valid = 0;
    logic [31:0] m_data = '0;
    string m_tag = "";
    bit    m_err = 0;

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit fire_in, fire_out, bad;
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R10", "reset out_valid", {31'b0, out_valid}, 32'h0);
        check(err_pulse == 1'b0, "R11", "reset err_pulse", {31'b0, err_pulse}, 32'h0);
        check(in_ready == 1'b1, "R10", "reset in_ready", {31'b0, in_ready}, 32'h1);
        rst = 1'b0;

        // R1 equal widths, mode ignored
        q.push_back(mk(32'h8765_4321, 2, 2, 1, 0, 0, 0));
        q.push_back(mk(32'hABCD_9F12, 1, 1, 1, 0, 0, 0));
        // R2 / R3 narrow to wide
        q.push_back(mk(32'h0000_0085, 0, 2, 0, 0, 0, 0));
        q.push_back(mk(32'h0000_0085, 0, 2, 1, 0, 0, 0));
        q.push_back(mk(32'h0000_8001, 1, 2, 1, 0, 0, 0));
        q.push_back(mk(32'h0000_0071, 0, 1, 1, 0, 0, 0));
        // R4 / R5 wide to narrow
        q.push_back(mk(32'hA1B2_C3D4, 2, 0, 0, 0, 0, 0));
        q.push_back(mk(32'hA1B2_C3D4, 2, 0, 1, 0, 0, 0));
        q.push_back(mk(32'hA1B2_C3D4, 2, 1, 1, 0, 0, 0));
        q.push_back(mk(32'h0000_C3D4, 1, 0, 1, 0, 0, 0));
        // R6 source exchange, word only
        q.push_back(mk(32'h4433_2211, 2, 2, 0, 1, 0, 0));
        q.push_back(mk(32'h0000_2211, 1, 1, 0, 1, 0, 0));
        q.push_back(mk(32'h4433_2211, 2, 1, 1, 1, 0, 0));
        // R7 / R8 destination exchanges
        q.push_back(mk(32'h4433_2211, 2, 2, 0, 0, 1, 0));
        q.push_back(mk(32'h0000_0011, 0, 0, 0, 0, 1, 1));
        q.push_back(mk(32'h0000_2211, 1, 1, 0, 0, 1, 1));
        q.push_back(mk(32'h4433_2211, 2, 2, 0, 0, 0, 1));
        q.push_back(mk(32'h4433_2211, 2, 2, 0, 0, 1, 1));
        q.push_back(mk(32'h0000_0090, 0, 2, 1, 0, 1, 1));
        // R9 junk above source width
        q.push_back(mk(32'hDEAD_BE5A, 0, 1, 0, 0, 0, 0));
        q.push_back(mk(32'hFFFF_0102, 1, 2, 0, 0, 0, 0));
        // R11 illegal widths, back to back
        q.push_back(mk(32'h1234_5678, 3, 2, 0, 0, 0, 0));
        q.push_back(mk(32'h1234_5678, 2, 3, 0, 0, 0, 0));
        q.push_back(mk(32'h1234_5678, 2, 2, 0, 0, 0, 0));
        for (int i = 0; i < 4000; i++) begin
            q.push_back(mk($urandom(), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1))));
        end

        forever begin
            @(negedge clk);
            bad      = (cur.sw == 2'd3 || cur.dw == 2'd3);
            fire_in  = in_valid && (!m_valid || out_ready);
            fire_out = m_valid && out_ready;
            m_err    = fire_in && bad;
            if (fire_in && !bad) begin
                m_valid = 1;
                m_data  = ref_beat(cur);
                m_tag   = tag_of(cur);
            end else if (fire_in || fire_out) begin
                m_valid = 0;
            end
            check(out_valid == m_valid, "R10", "out_valid", {31'b0, out_valid}, {31'b0, m_valid});
            if (m_valid && out_valid)
                check(out_data == m_data, m_tag, "out_data", out_data, m_data);
            check(err_pulse == m_err, "R11", "err_pulse", {31'b0, err_pulse}, {31'b0, m_err});

            if (!(in_valid && !fire_in)) begin
                if (q.size() > 0 && $urandom_range(0, 3) != 0) begin
                    cur        = q.pop_front();
                    in_data    = cur.d;
                    src_width  = cur.sw;
                    dst_width  = cur.dw;
                    fit_mode   = cur.m;
                    src_swap_b = cur.sbx;
                    dst_swap_b = cur.dbx;
                    dst_swap_h = cur.dhx;
                    in_valid   = 1'b1;
                end else begin
                    in_valid = 1'b0;
                end
            end
            out_ready = ($urandom_range(0, 3) != 0);
            #1;
            check(in_ready == (!m_valid || out_ready), "R10", "in_ready",
                  {31'b0, in_ready}, {31'b0, (!m_valid || out_ready)});
            if (q.size() == 0 && !in_valid && !m_valid) break;
        end
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule